// File: doc/BRIEF.md
# Branch Checkpoint Queue

This block keeps copies of the register rename map so the pipeline can recover after a mispredicted branch. Each time a branch has been renamed, the rename stage offers the current map on an allocate stream. The block stores it in a free slot and returns a 2-bit tag. The branch carries that tag until it resolves. Slots are allocated at the tail and released at the head, in strict first-in first-out order. Four slots are provided, so at most four branches can be in flight at once.

A resolve request names a tag and says whether the branch was mispredicted. If the prediction was correct, the block releases the oldest slot and leaves the current map alone. If it was mispredicted, the block drives the saved map for that tag on the restore output for one cycle. In the same step it discards that slot and every younger slot, so the next allocation reuses the mispredicted branch's tag. Slots older than the failing branch are kept.

The allocate side is a valid/ready stream. A transfer happens on a rising clock edge where `alloc_valid` and `alloc_ready` are both high. `alloc_ready` is low while all slots are occupied. It is also low in any cycle that carries a mispredict resolve request, because an allocation in that cycle would belong to the flushed, younger path. The rename stage must hold the branch, with `alloc_valid` and `alloc_map` stable, until a transfer happens. The resolve port and the restore output are plain control pins with no handshake. The slot count must be a power of two.

Top module: `branch_ckpt_queue`

## Requirements
- R1: After reset the queue is empty: `full` is 0, `alloc_ready` is 1, `restore_valid` is 0 and `alloc_tag` is 0.
- R2: `alloc_tag` shows the slot number (0 to 3) that the next accepted allocation will use. The first allocation after reset gets tag 0, and each accepted allocation advances the tag by one modulo 4.
- R3: `full` is 1 exactly when four slots are held. While `full` is 1, `alloc_ready` is 0 and an offered allocation stores nothing and does not change the occupancy.
- R4: A resolve with `res_mispredict`=0 whose tag names the oldest held slot releases that slot and does not raise `restore_valid`.
- R5: A resolve whose tag names no held slot is ignored. A correct-prediction resolve whose tag is not the oldest held slot is also ignored.
- R6: A mispredict resolve that names a held slot makes `restore_valid` 1 in the following cycle only, with `restore_map` equal to the map stored under that tag. `restore_valid` is never 1 in any other cycle.
- R7: A mispredict resolve discards the named slot and all younger slots and keeps the older ones. In the next cycle, `alloc_tag` equals the mispredicted tag.
- R8: In a cycle with `res_valid`=1 and `res_mispredict`=1, `alloc_ready` is 0 and an offered allocation is not stored.
- R9: An accepted allocation and a correct-prediction release of the oldest slot in the same cycle both take effect: occupancy is unchanged and the new map is stored at the old tail tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | A renamed branch offers its map for capture |
| alloc_ready | output | 1 | A slot can accept the offered map this cycle |
| alloc_map | input | ARCH_REGS*PREG_W (192) | Rename map to save, entry k in bits [k*PREG_W +: PREG_W] |
| alloc_tag | output | TAG_W (2) | Tag the next accepted allocation receives |
| full | output | 1 | All slots are held; rename of another branch must stall |
| res_valid | input | 1 | A branch outcome is presented this cycle |
| res_tag | input | TAG_W (2) | Tag of the resolving branch |
| res_mispredict | input | 1 | 1 if the resolving branch was mispredicted |
| restore_valid | output | 1 | One-cycle pulse: restore_map must be loaded into the rename map |
| restore_map | output | ARCH_REGS*PREG_W (192) | Saved map of the mispredicted branch |

## Verification
`alloc_ready`, `alloc_tag` and `full` are combinational. They depend only on the state and the resolve inputs of the current cycle, so the bench checks them a short settling delay after it drives its inputs. Allocations, releases and flushes take effect at the next rising edge. `restore_valid` and `restore_map` are registered and are due one edge after the mispredict request, so the bench checks them at the falling edge that follows that edge, against a reference queue model updated at the same point. Directed sequences cover filling, refusals while full, ignored resolves, partial flushes and allocate-with-release. Seeded random traffic covers the remaining mix.

// File: rtl/bcq_pkg.sv
package bcq_pkg;
  // Effect of a resolve request on the queue
  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,
    RES_FREE  = 2'd1,
    RES_FLUSH = 2'd2
  } res_act_e;
endpackage

// File: rtl/bcq_ptr_ctrl.sv
module bcq_ptr_ctrl
  import bcq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TAG_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  output logic             alloc_ready,
  output logic             alloc_fire,
  output logic [TAG_W-1:0] tail_idx,
  output logic             full,
  input  logic             res_valid,
  input  logic [TAG_W-1:0] res_tag,
  input  logic             res_mispredict,
  output res_act_e         act
);
  logic [TAG_W-1:0] head_q;
  logic [CNT_W-1:0] count_q;
  logic [TAG_W-1:0] age_off;
  logic             tag_live;

  // Age of the resolving tag relative to the oldest slot
  assign age_off  = res_tag - head_q;
  assign tag_live = CNT_W'(age_off) < count_q;
  assign tail_idx = head_q + count_q[TAG_W-1:0];
  assign full     = (count_q == CNT_W'(DEPTH));

  assign alloc_ready = !full && !(res_valid && res_mispredict);
  assign alloc_fire  = alloc_valid && alloc_ready;

  always_comb begin
    act = RES_NONE;
    if (res_valid && tag_live) begin
      if (res_mispredict)                act = RES_FLUSH;
      else if (age_off == '0)            act = RES_FREE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      count_q <= '0;
    end else begin
      unique case (act)
        RES_FLUSH: count_q <= CNT_W'(age_off);
        RES_FREE: begin
          head_q  <= head_q + TAG_W'(1);
          count_q <= count_q - CNT_W'(1) + CNT_W'(alloc_fire);
        end
        default:   count_q <= count_q + CNT_W'(alloc_fire);
      endcase
    end
  end
endmodule

// File: rtl/bcq_store.sv
module bcq_store #(
  parameter int DEPTH = 4,
  parameter int MAP_W = 192,
  parameter int TAG_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_idx,
  input  logic [MAP_W-1:0] wr_map,
  input  logic [TAG_W-1:0] rd_idx,
  output logic [MAP_W-1:0] rd_map
);
  logic [MAP_W-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0] slot_we;

  for (genvar i = 0; i < DEPTH; i++) begin : g_we
    assign slot_we[i] = wr_en && (wr_idx == TAG_W'(i));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_we[i]) slot_q[i] <= wr_map;
    end
  end

  assign rd_map = slot_q[rd_idx];
endmodule

// File: rtl/bcq_restore.sv
module bcq_restore
  import bcq_pkg::*;
#(
  parameter int MAP_W = 192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  res_act_e         act,
  input  logic [MAP_W-1:0] rd_map,
  output logic             restore_valid,
  output logic [MAP_W-1:0] restore_map
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) restore_valid <= 1'b0;
    else        restore_valid <= (act == RES_FLUSH);
  end

  always_ff @(posedge clk) begin
    if (act == RES_FLUSH) restore_map <= rd_map;
  end
endmodule

// File: rtl/branch_ckpt_queue.sv
module branch_ckpt_queue
  import bcq_pkg::*;
#(
  parameter int ARCH_REGS = 32,
  parameter int PREG_W    = 6,
  parameter int DEPTH     = 4,
  parameter int MAP_W     = ARCH_REGS * PREG_W,
  parameter int TAG_W     = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  output logic             alloc_ready,
  input  logic [MAP_W-1:0] alloc_map,
  output logic [TAG_W-1:0] alloc_tag,
  output logic             full,
  input  logic             res_valid,
  input  logic [TAG_W-1:0] res_tag,
  input  logic             res_mispredict,
  output logic             restore_valid,
  output logic [MAP_W-1:0] restore_map
);
  logic             alloc_fire;
  logic [TAG_W-1:0] tail_idx;
  logic [MAP_W-1:0] rd_map;
  res_act_e         act;

  assign alloc_tag = tail_idx;

  bcq_ptr_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_fire(alloc_fire), .tail_idx(tail_idx), .full(full),
    .res_valid(res_valid), .res_tag(res_tag),
    .res_mispredict(res_mispredict), .act(act)
  );

  bcq_store #(.DEPTH(DEPTH), .MAP_W(MAP_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .wr_en(alloc_fire), .wr_idx(tail_idx), .wr_map(alloc_map),
    .rd_idx(res_tag), .rd_map(rd_map)
  );

  bcq_restore #(.MAP_W(MAP_W)) u_restore (
    .clk(clk), .rst_n(rst_n), .act(act), .rd_map(rd_map),
    .restore_valid(restore_valid), .restore_map(restore_map)
  );
endmodule

// File: rtl/bcq_checker.sv
module bcq_checker #(
  parameter int TAG_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_ready,
  input logic             full,
  input logic             res_valid,
  input logic             res_mispredict,
  input logic             restore_valid,
  input logic [TAG_W-1:0] alloc_tag,
  input logic [TAG_W-1:0] res_tag
);
  p_no_accept_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc_ready);

  p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !res_valid) |=> full);

  p_no_accept_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_mispredict) |-> !alloc_ready);

  p_restore_only_after_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && res_mispredict) |=> !restore_valid);

  p_correct_no_restore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_mispredict) |=> !restore_valid);

  p_tail_rewind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |-> (alloc_tag == $past(res_tag)));
endmodule

bind branch_ckpt_queue bcq_checker #(.TAG_W(TAG_W)) u_bcq_chk (.*);

// File: tb/branch_ckpt_queue_test.sv
`timescale 1ns/1ps
module branch_ckpt_queue_test;
  localparam int MAP_W = 192;
  localparam int TAG_W = 2;
  localparam int DEPTH = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             alloc_valid = 1'b0;
  logic             alloc_ready;
  logic [MAP_W-1:0] alloc_map = '0;
  logic [TAG_W-1:0] alloc_tag;
  logic             full;
  logic             res_valid = 1'b0;
  logic [TAG_W-1:0] res_tag = '0;
  logic             res_mispredict = 1'b0;
  logic             restore_valid;
  logic [MAP_W-1:0] restore_map;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  // reference queue
  logic [MAP_W-1:0] m_slot [DEPTH];
  int m_head = 0;
  int m_count = 0;

  always #4 clk = ~clk;

  branch_ckpt_queue uut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_map(alloc_map), .alloc_tag(alloc_tag), .full(full),
    .res_valid(res_valid), .res_tag(res_tag), .res_mispredict(res_mispredict),
    .restore_valid(restore_valid), .restore_map(restore_map)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 60000 && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [MAP_W-1:0] act, input logic [MAP_W-1:0] exp);
    tests = tests + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [MAP_W-1:0] rand_map();
    logic [MAP_W-1:0] m;
    for (int k = 0; k < MAP_W / 32; k++) m[k*32 +: 32] = $urandom;
    return m;
  endfunction

  function automatic bit exp_ready(input bit rv, input bit rmis);
    return (m_count != DEPTH) && !(rv && rmis);
  endfunction

  // One clock: drive after a falling edge, check combinational outputs,
  // advance the model at the rising edge, check registered outputs at the next falling edge.
  task automatic step(input bit av, input logic [MAP_W-1:0] amap,
                      input bit rv, input int rtag, input bit rmis);
    int off;
    bit live, fire, exp_rv;
    logic [MAP_W-1:0] exp_map;
    alloc_valid = av; alloc_map = amap;
    res_valid = rv; res_tag = TAG_W'(rtag); res_mispredict = rmis;
    #1;
    chk("R3/R8 alloc_ready", MAP_W'(alloc_ready), MAP_W'(exp_ready(rv, rmis)));
    chk("R2 alloc_tag", MAP_W'(alloc_tag), MAP_W'((m_head + m_count) % DEPTH));
    chk("R3 full", MAP_W'(full), MAP_W'(m_count == DEPTH));
    off  = (rtag - m_head + DEPTH) % DEPTH;
    live = rv && (off < m_count);
    fire = av && exp_ready(rv, rmis);
    exp_rv = 1'b0;
    exp_map = '0;
    if (live && rmis) begin
      exp_rv = 1'b1;
      exp_map = m_slot[rtag];
      m_count = off;
    end else begin
      if (fire) begin
        m_slot[(m_head + m_count) % DEPTH] = amap;
        m_count = m_count + 1;
      end
      if (live && off == 0) begin
        m_head = (m_head + 1) % DEPTH;
        m_count = m_count - 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk("R6 restore_valid", MAP_W'(restore_valid), MAP_W'(exp_rv));
    if (exp_rv) chk("R6 restore_map", restore_map, exp_map);
  endtask

  logic [MAP_W-1:0] a [5];
  logic [MAP_W-1:0] b0, b1, xmap;

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 5; i++) a[i] = rand_map();
    b0 = rand_map(); b1 = rand_map(); xmap = rand_map();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 full", MAP_W'(full), '0);
    chk("R1 alloc_ready", MAP_W'(alloc_ready), MAP_W'(1));
    chk("R1 restore_valid", MAP_W'(restore_valid), '0);
    chk("R1 alloc_tag", MAP_W'(alloc_tag), '0);
    @(negedge clk);

    // R2 fill four slots with tags 0..3
    for (int i = 0; i < 4; i++) step(1, a[i], 0, 0, 0);
    chk("R3 full after four", MAP_W'(full), MAP_W'(1));
    // R3 offer while full: refused
    step(1, xmap, 0, 0, 0);
    chk("R3 still full", MAP_W'(full), MAP_W'(1));
    // R5 correct resolve of a non-oldest tag is ignored
    step(0, '0, 1, 2, 0);
    chk("R5 non-oldest ignored", MAP_W'(full), MAP_W'(1));
    // R4 release oldest
    step(0, '0, 1, 0, 0);
    chk("R4 release full", MAP_W'(full), '0);
    chk("R4 no restore", MAP_W'(restore_valid), '0);
    chk("R4 next tag", MAP_W'(alloc_tag), MAP_W'(0));
    step(1, a[4], 0, 0, 0);
    chk("R3 one slot only", MAP_W'(full), MAP_W'(1));
    // R6/R7 mispredict tag 2: keep slot 1 only
    step(0, '0, 1, 2, 1);
    chk("R6 restore A2", restore_map, a[2]);
    chk("R7 rewind tag", MAP_W'(alloc_tag), MAP_W'(2));
    // R5 mispredict of a discarded tag is ignored
    step(0, '0, 1, 3, 1);
    chk("R5 dead tag no restore", MAP_W'(restore_valid), '0);
    // R8 mispredict tag 1 with an offered allocation
    alloc_valid = 1'b1; res_valid = 1'b1; res_tag = 2'd1; res_mispredict = 1'b1;
    #1;
    chk("R8 ready low", MAP_W'(alloc_ready), '0);
    step(1, xmap, 1, 1, 1);
    chk("R8 restore A1", restore_map, a[1]);
    chk("R8 not stored", MAP_W'(alloc_tag), MAP_W'(1));
    // R9 allocate while releasing oldest
    step(1, b0, 0, 0, 0);
    step(1, b1, 1, 1, 0);
    chk("R9 tail advanced", MAP_W'(alloc_tag), MAP_W'(3));
    step(0, '0, 1, 2, 1);
    chk("R9 restore B1", restore_map, b1);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      int rt;
      bit rv, rm, av;
      av = ($urandom % 3) != 0;
      rv = ($urandom % 3) == 0;
      rm = ($urandom % 4) == 0;
      rt = ($urandom % 2) ? m_head : int'($urandom % DEPTH);
      step(av, rand_map(), rv, rt, rm);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule